// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block sits between a UART's receive and transmit FIFOs and its modem-control pins. On the transmit side it turns the clear-to-send input into a transmit-permit signal for the transmitter. CTS is brought into the clock domain first. A HIGH level holds off the start of the next frame, and a frame already being shifted out is allowed to finish.

On the receive side it drives the RTS pin from the receive FIFO fill level. It uses two thresholds, so the pin has hysteresis. The pin rises once the level climbs to the halt threshold. It falls again once the level drains to the resume threshold. Between the two it keeps its last value. Each threshold is a 4-bit nibble scaled by four to cover a 64-entry FIFO.

Every received byte passes through to the FIFO write port one cycle later. The block can also compare each byte with a programmed special character. A match still stores the byte, and it sets a sticky flag that feeds interrupt-identification bit 4. The flag clears when the host reads the interrupt-identification register.

Top module: `uart_autoflow`

## Requirements
- R1: After a synchronous reset, the internal RTS state is LOW, the special-character flag is 0, the FIFO write strobe is 0 and the transmit permit is 1.
- R2: With CTS gating enabled (`mode_cfg[2]`=1), a HIGH on `cts_pin` drives `tx_permit` to 0 no later than the third rising edge after the change, as long as no frame is in flight. A LOW on `cts_pin` returns it to 1 within the same delay.
- R3: With `mode_cfg[2]`=0, `tx_permit` is 1 whatever the level on `cts_pin`.
- R4: While `tx_busy` is 1 (a frame is being shifted out), `tx_permit` stays 1 even when the synchronized CTS is HIGH.
- R5: With automatic RTS enabled (`mode_cfg[1]`=1), `rts` is 1 in the cycle after `rx_level` >= 4*`thresh_cfg[3:0]`. The halt test takes priority over the resume test.
- R6: With automatic RTS enabled, `rts` is 0 in the cycle after `rx_level` <= 4*`thresh_cfg[7:4]`, provided the halt condition does not hold.
- R7: With automatic RTS enabled, `rts` keeps its previous value while `rx_level` lies strictly between the resume and halt thresholds.
- R8: With `mode_cfg[1]`=0, `rts` equals the `rts_manual` input, whatever the FIFO level.
- R9: Each cycle with `rx_valid`=1 produces `fifo_wr`=1 on the next cycle with `fifo_wdata` equal to the received byte, matched or not. With `rx_valid`=0, `fifo_wr` is 0 on the next cycle.
- R10: With special-character detect enabled (`mode_cfg[0]`=1), a received byte equal to `spchar` sets `spchar_flag` on the next cycle.
- R11: `spchar_flag` stays set until a cycle with `iir_rd`=1, which clears it on the next cycle. A new match in the same cycle as the read wins, and the flag stays set.
- R12: With `mode_cfg[0]`=0, a byte equal to `spchar` leaves `spchar_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 3 | Enables: [2] CTS gating, [1] automatic RTS, [0] special-character detect |
| thresh_cfg | input | 8 | [3:0] halt nibble, [7:4] resume nibble, each scaled by 4 |
| spchar | input | 8 | Special character to compare against |
| rx_level | input | LVL_W (7) | Current receive FIFO fill level |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| iir_rd | input | 1 | Host read of the interrupt-identification register |
| cts_pin | input | 1 | Clear-to-send pin, HIGH means stop |
| tx_busy | input | 1 | Transmitter is shifting out a frame |
| rts_manual | input | 1 | RTS level used when automatic RTS is off |
| rts | output | 1 | Request-to-send pin |
| tx_permit | output | 1 | Transmitter may start a new frame |
| spchar_flag | output | 1 | Sticky special-character flag (interrupt-identification bit 4) |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Byte written to the receive FIFO |

## Verification
On every cycle, the assertions check several behaviours. They check the RTS hysteresis rules against the thresholds, the manual RTS bypass, and the rule that the permit stays high when CTS gating is off or a frame is in flight. They also check the one-cycle pass-through of received bytes, and that the special-character flag is set, held and cleared correctly. Other behaviours can only be shown by the bench's scenarios. These are the delay from the CTS pin through the synchronizer to the permit, the RTS sequences that walk the level up through the halt threshold and back down through the band to the resume threshold, and the case where a read and a match fall in the same cycle.

// File: rtl/uart_autoflow_pkg.sv
package uart_autoflow_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CMP_W  = 16;

    // positions inside mode_cfg
    localparam int unsigned MODE_CTS = 2;
    localparam int unsigned MODE_RTS = 1;
    localparam int unsigned MODE_SPC = 0;

    typedef struct packed {
        logic cts_gate;
        logic rts_auto;
        logic spc_det;
    } flow_mode_t;

    typedef enum logic {
        RTS_GO   = 1'b0,
        RTS_HALT = 1'b1
    } rts_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;

    function automatic flow_mode_t decode_mode(input logic [2:0] cfg);
        flow_mode_t m;
        m.cts_gate = cfg[MODE_CTS];
        m.rts_auto = cfg[MODE_RTS];
        m.spc_det  = cfg[MODE_SPC];
        return m;
    endfunction

    function automatic logic [CMP_W-1:0] scale_nibble(input logic [3:0] nib,
                                                      input int unsigned sh);
        return CMP_W'(nib) << sh;
    endfunction

endpackage

// File: rtl/uaf_tx_gate.sv
module uaf_tx_gate #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_en,
    input  logic cts_pin,
    input  logic tx_busy,
    output logic tx_permit
);

    logic cts_sync;

    generate
        if (SYNC_STAGES <= 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b0;
                else     s_q <= cts_pin;
            end
            assign cts_sync = s_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= '0;
                else     s_q <= {s_q[SYNC_STAGES-2:0], cts_pin};
            end
            assign cts_sync = s_q[SYNC_STAGES-1];
        end
    endgenerate

    // only the start of a frame is held off; a frame in flight finishes
    always_comb begin
        tx_permit = 1'b1;
        if (gate_en && cts_sync && !tx_busy)
            tx_permit = 1'b0;
    end

endmodule

// File: rtl/uaf_rts_ctrl.sv
module uaf_rts_ctrl
    import uart_autoflow_pkg::*;
#(
    parameter int unsigned LVL_W    = 7,
    parameter int unsigned SCALE_SH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             rts_manual,
    input  logic [3:0]       halt_nib,
    input  logic [3:0]       resume_nib,
    input  logic [LVL_W-1:0] rx_level,
    output logic             rts
);

    rts_state_e       state_q, state_d;
    logic [CMP_W-1:0] halt_lvl, resume_lvl, level_ext;
    logic             at_halt, at_resume;

    always_comb begin
        halt_lvl   = scale_nibble(halt_nib, SCALE_SH);
        resume_lvl = scale_nibble(resume_nib, SCALE_SH);
        level_ext  = CMP_W'(rx_level);
        at_halt    = level_ext >= halt_lvl;
        at_resume  = level_ext <= resume_lvl;
    end

    always_comb begin
        state_d = state_q;
        if (!auto_en)       state_d = RTS_GO;
        else if (at_halt)   state_d = RTS_HALT;
        else if (at_resume) state_d = RTS_GO;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RTS_GO;
        else     state_q <= state_d;
    end

    assign rts = auto_en ? (state_q == RTS_HALT) : rts_manual;

endmodule

// File: rtl/uaf_spchar_det.sv
module uaf_spchar_det
    import uart_autoflow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              det_en,
    input  logic [BYTE_W-1:0] spchar,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              iir_rd,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              spchar_flag
);

    rx_beat_t beat_q;
    logic     flag_q;
    logic     hit;

    assign hit = det_en && rx_valid && (rx_data == spchar);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= rx_valid;
            if (rx_valid) beat_q.data <= rx_data;
        end
    end

    // a fresh match outranks a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (hit)    flag_q <= 1'b1;
        else if (iir_rd) flag_q <= 1'b0;
    end

    assign fifo_wr     = beat_q.valid;
    assign fifo_wdata  = beat_q.data;
    assign spchar_flag = flag_q;

endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
    import uart_autoflow_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 64,
    parameter int unsigned SCALE_SH    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_cfg,
    input  logic [7:0]       thresh_cfg,
    input  logic [7:0]       spchar,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             iir_rd,
    input  logic             cts_pin,
    input  logic             tx_busy,
    input  logic             rts_manual,
    output logic             rts,
    output logic             tx_permit,
    output logic             spchar_flag,
    output logic             fifo_wr,
    output logic [7:0]       fifo_wdata
);

    flow_mode_t mode;
    assign mode = decode_mode(mode_cfg);

    uaf_tx_gate #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tx_gate (
        .clk       (clk),
        .rst       (rst),
        .gate_en   (mode.cts_gate),
        .cts_pin   (cts_pin),
        .tx_busy   (tx_busy),
        .tx_permit (tx_permit)
    );

    uaf_rts_ctrl #(
        .LVL_W    (LVL_W),
        .SCALE_SH (SCALE_SH)
    ) u_rts_ctrl (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (mode.rts_auto),
        .rts_manual (rts_manual),
        .halt_nib   (thresh_cfg[3:0]),
        .resume_nib (thresh_cfg[7:4]),
        .rx_level   (rx_level),
        .rts        (rts)
    );

    uaf_spchar_det u_spchar_det (
        .clk         (clk),
        .rst         (rst),
        .det_en      (mode.spc_det),
        .spchar      (spchar),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .iir_rd      (iir_rd),
        .fifo_wr     (fifo_wr),
        .fifo_wdata  (fifo_wdata),
        .spchar_flag (spchar_flag)
    );

endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk #(
    parameter int unsigned SCALE_SH = 2,
    parameter int unsigned LVL_W    = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       mode_cfg,
    input logic [7:0]       thresh_cfg,
    input logic [7:0]       spchar,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_valid,
    input logic [7:0]       rx_data,
    input logic             iir_rd,
    input logic             tx_busy,
    input logic             rts_manual,
    input logic             rts,
    input logic             tx_permit,
    input logic             spchar_flag,
    input logic             fifo_wr,
    input logic [7:0]       fifo_wdata
);

    logic [15:0] lvl16, hi_mark, lo_mark;
    logic        auto_on, match_now;

    assign lvl16     = 16'(rx_level);
    assign hi_mark   = 16'(thresh_cfg[3:0]) << SCALE_SH;
    assign lo_mark   = 16'(thresh_cfg[7:4]) << SCALE_SH;
    assign auto_on   = mode_cfg[1];
    assign match_now = mode_cfg[0] && rx_valid && (rx_data == spchar);

    // R3
    cts_off_permit_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_cfg[2] |-> tx_permit);

    // R4
    busy_permit_chk: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> tx_permit);

    // R5
    rts_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_on && lvl16 >= hi_mark) |=> (!mode_cfg[1] || rts));

    // R6
    rts_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_on && lvl16 < hi_mark && lvl16 <= lo_mark) |=> (!mode_cfg[1] || !rts));

    // R7
    rts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_on && lvl16 < hi_mark && lvl16 > lo_mark) |=>
            (!mode_cfg[1] || rts == $past(rts)));

    // R8
    rts_manual_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_on |-> (rts == rts_manual));

    // R9
    push_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (fifo_wr && fifo_wdata == $past(rx_data)));

    // R9
    no_push_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !fifo_wr);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        match_now |=> spchar_flag);

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spchar_flag && !iir_rd) |=> spchar_flag);

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && !match_now) |=> !spchar_flag);

    // R12
    flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!spchar_flag && !match_now) |=> !spchar_flag);

endmodule

bind uart_autoflow uart_autoflow_chk #(
    .SCALE_SH (SCALE_SH),
    .LVL_W    (LVL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_cfg    (mode_cfg),
    .thresh_cfg  (thresh_cfg),
    .spchar      (spchar),
    .rx_level    (rx_level),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .iir_rd      (iir_rd),
    .tx_busy     (tx_busy),
    .rts_manual  (rts_manual),
    .rts         (rts),
    .tx_permit   (tx_permit),
    .spchar_flag (spchar_flag),
    .fifo_wr     (fifo_wr),
    .fifo_wdata  (fifo_wdata)
);

// File: tb/uart_autoflow_bench.sv
`timescale 1ns/1ps
module uart_autoflow_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_cfg = 3'b000;
    logic [7:0] thresh_cfg = 8'h00;
    logic [7:0] spchar = 8'h00;
    logic [6:0] rx_level = 7'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       iir_rd = 1'b0;
    logic       cts_pin = 1'b0;
    logic       tx_busy = 1'b0;
    logic       rts_manual = 1'b0;
    logic       rts, tx_permit, spchar_flag, fifo_wr;
    logic [7:0] fifo_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_autoflow u_uart_autoflow (
        .clk         (clk),
        .rst         (rst),
        .mode_cfg    (mode_cfg),
        .thresh_cfg  (thresh_cfg),
        .spchar      (spchar),
        .rx_level    (rx_level),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .iir_rd      (iir_rd),
        .cts_pin     (cts_pin),
        .tx_busy     (tx_busy),
        .rts_manual  (rts_manual),
        .rts         (rts),
        .tx_permit   (tx_permit),
        .spchar_flag (spchar_flag),
        .fifo_wr     (fifo_wr),
        .fifo_wdata  (fifo_wdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic rd);
        rx_valid = 1'b1;
        rx_data  = b;
        iir_rd   = rd;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        iir_rd   = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rts", {7'd0, rts}, 8'd0);
        check("R1 permit", {7'd0, tx_permit}, 8'd1);
        check("R1 flag", {7'd0, spchar_flag}, 8'd0);
        check("R1 fifo_wr", {7'd0, fifo_wr}, 8'd0);
    endtask

    task automatic t_cts_gate;
        mode_cfg = 3'b100;
        cts_pin  = 1'b1;
        step(3);
        check("R2 cts high", {7'd0, tx_permit}, 8'd0);
        tx_busy = 1'b1;
        step(1);
        check("R4 busy", {7'd0, tx_permit}, 8'd1);
        tx_busy = 1'b0;
        step(1);
        check("R2 after frame", {7'd0, tx_permit}, 8'd0);
        cts_pin = 1'b0;
        step(3);
        check("R2 cts low", {7'd0, tx_permit}, 8'd1);
    endtask

    task automatic t_cts_off;
        mode_cfg = 3'b000;
        cts_pin  = 1'b1;
        step(4);
        check("R3 gating off", {7'd0, tx_permit}, 8'd1);
        cts_pin = 1'b0;
        step(3);
    endtask

    task automatic t_rts;
        mode_cfg   = 3'b010;
        thresh_cfg = 8'h48;   // halt 32, resume 16
        rx_level   = 7'd10;
        step(1);
        check("R6 low start", {7'd0, rts}, 8'd0);
        rx_level = 7'd31;
        step(1);
        check("R7 band from low", {7'd0, rts}, 8'd0);
        rx_level = 7'd32;
        step(1);
        check("R5 halt", {7'd0, rts}, 8'd1);
        rx_level = 7'd20;
        step(1);
        check("R7 band from high", {7'd0, rts}, 8'd1);
        rx_level = 7'd16;
        step(1);
        check("R6 resume", {7'd0, rts}, 8'd0);
        rx_level = 7'd60;
        step(1);
        check("R5 high level", {7'd0, rts}, 8'd1);
        thresh_cfg = 8'h40;   // halt 0 wins over resume
        rx_level   = 7'd0;
        step(1);
        check("R5 halt priority", {7'd0, rts}, 8'd1);
    endtask

    task automatic t_rts_manual;
        mode_cfg   = 3'b000;
        thresh_cfg = 8'h48;
        rts_manual = 1'b1;
        rx_level   = 7'd0;
        step(1);
        check("R8 manual high", {7'd0, rts}, 8'd1);
        rts_manual = 1'b0;
        rx_level   = 7'd63;
        step(1);
        check("R8 manual low", {7'd0, rts}, 8'd0);
    endtask

    task automatic t_spchar;
        mode_cfg = 3'b001;
        spchar   = 8'h13;
        send_byte(8'h41, 1'b0);
        check("R9 wr", {7'd0, fifo_wr}, 8'd1);
        check("R9 data", fifo_wdata, 8'h41);
        check("R10 no match", {7'd0, spchar_flag}, 8'd0);
        send_byte(8'h13, 1'b0);
        check("R9 match stored", fifo_wdata, 8'h13);
        check("R10 match", {7'd0, spchar_flag}, 8'd1);
        step(2);
        check("R9 idle", {7'd0, fifo_wr}, 8'd0);
        check("R11 sticky", {7'd0, spchar_flag}, 8'd1);
        iir_rd = 1'b1;
        step(1);
        iir_rd = 1'b0;
        check("R11 cleared", {7'd0, spchar_flag}, 8'd0);
        send_byte(8'h13, 1'b1);
        check("R11 set wins", {7'd0, spchar_flag}, 8'd1);
        iir_rd = 1'b1;
        step(1);
        iir_rd = 1'b0;
    endtask

    task automatic t_spchar_off;
        mode_cfg = 3'b000;
        send_byte(8'h13, 1'b0);
        check("R12 wr", {7'd0, fifo_wr}, 8'd1);
        check("R12 no flag", {7'd0, spchar_flag}, 8'd0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_cts_gate();
        t_cts_off();
        t_rts();
        t_rts_manual();
        t_spchar();
        t_spchar_off();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule